// File: doc/BRIEF.md
# Reloadable Watchdog Timer

The block is a watchdog that counts down in slow ticks of 0.2 seconds. It makes each tick from the system clock with its own prescaler. A host reaches it through a small byte-wide register port. The host sets a 4-bit reload value and arms the watchdog by writing a key code. After that the host must keep hitting a trigger bit, and each hit restarts the countdown from the reload value.

If the countdown runs out, the block drives a reset pulse of fixed length to the system reset controller, which is outside this block, and disarms itself. The host must write the key again to rearm it. A status register reports the armed flag and the live count, so software can see how close the countdown is to expiry.

Register addresses: 0 holds the reload value, 1 is the arm control, 2 is the trigger, and 3 is the read-only status.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed, the count is 0, the status read (address 3) returns 0x00 and `wdt_rst_o` is low.
- R2: A write to address 0 stores `wr_data[3:0]` as the reload value. A read of address 0 returns the reload value in bits 3:0 with bits 7:4 zero.
- R3: Writing exactly 0x5A to address 1 arms the watchdog, loads the count from the reload value and restarts the tick prescaler.
- R4: Writing any value other than 0x5A to address 1 disarms the watchdog. While disarmed the count holds its value and no reset pulse is produced.
- R5: While armed, one tick occurs every `CLK_PER_TICK` clock cycles, counted from the last arm or trigger, and each tick lowers the count by one. With reload value N (N ≥ 1), the pulse starts `N*CLK_PER_TICK` cycles after the arming write.
- R6: When a tick brings the count to 0, `wdt_rst_o` goes high for exactly `PULSE_CYCLES` cycles and the watchdog disarms itself (status bit 7 reads 0).
- R7: While armed, writing address 2 with bit 0 set reloads the count from the reload value and restarts the prescaler. The same write is ignored while disarmed, and a write to address 2 with bit 0 clear has no effect.
- R8: The status read (address 3) returns the armed flag in bit 7, zeros in bits 6:4 and the current count in bits 3:0.
- R9: A reload value of 0 makes the watchdog expire on the first tick after arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| wdt_rst_o | output | 1 | Reset pulse to the system reset controller |

## Verification
The assertions check four rules on every cycle:
- a disarmed count never moves;
- an armed count never rises without a host write;
- an arm or trigger loads the reload value;
- every rising edge of the reset pulse coincides with the watchdog being disarmed.

The exact expiry cycle, the pulse width, the effect of a trigger midway through the countdown, the immediate expiry with reload 0 and the absence of a pulse after a disarm are shown only by the bench scenarios. A scoreboard predicts each pulse start from the write times.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int          CLK_PER_TICK = 50_000_000,
  parameter int          PULSE_CYCLES = 16,
  parameter logic [7:0]  ARM_KEY      = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wdt_rst_o
);
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int QW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(CLK_PER_TICK - 1);

  logic [3:0]    reload_q, count_q;
  logic          armed_q;
  logic [PW-1:0] presc_q;
  logic [QW-1:0] pulse_q;

  wire wr_reload = wr_en && (wr_addr == 2'd0);
  wire wr_arm    = wr_en && (wr_addr == 2'd1);
  wire arm_ok    = wr_arm && (wr_data == ARM_KEY);
  wire kick      = wr_en && (wr_addr == 2'd2) && wr_data[0] && armed_q;
  wire restart   = arm_ok || kick;
  wire tick      = armed_q && (presc_q == PRESC_LAST);
  wire fire      = tick && !restart && !wr_arm && (count_q <= 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      armed_q  <= 1'b0;
      count_q  <= '0;
      presc_q  <= '0;
      pulse_q  <= '0;
    end else begin
      if (wr_reload) reload_q <= wr_data[3:0];

      if (wr_arm)    armed_q <= arm_ok;
      else if (fire) armed_q <= 1'b0;

      if (restart)                count_q <= reload_q;
      else if (tick && !wr_arm)   count_q <= fire ? 4'd0 : count_q - 4'd1;

      if (restart || !armed_q || tick) presc_q <= '0;
      else                             presc_q <= presc_q + 1'b1;

      if (fire)                pulse_q <= QW'(PULSE_CYCLES);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end
  end

  assign wdt_rst_o = (pulse_q != '0);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {4'h0, reload_q};
      2'd3:    rd_data = {armed_q, 3'b000, count_q};
      default: rd_data = 8'h00;
    endcase
  end

  assert_disarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_ok) |=> $stable(count_q));

  assert_no_count_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !wr_en) |=> (count_q <= $past(count_q)));

  assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (armed_q && count_q == $past(reload_q)));

  assert_kick_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !wr_arm) |=> (armed_q && count_q == $past(reload_q)));

  assert_fire_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> !armed_q);
endmodule

// File: tb/tick_watchdog_tb.sv
module tick_watchdog_tb;
  localparam int P     = 10;
  localparam int PULSE = 16;

  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       wdt_rst_o;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  tick_watchdog #(.CLK_PER_TICK(P), .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_o(wdt_rst_o));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 e = cyc;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input int exp);
    @(negedge clk);
    rd_addr = a;
    #1 check(req, rd_data, exp);
  endtask

  task automatic expect_pulse(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  // monitor: compares pulse start and width against the scoreboard
  initial begin
    bit prev = 0;
    int width = 0;
    forever begin
      @(negedge clk);
      if (wdt_rst_o && !prev) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: actual pulse at %0d expected none", cyc);
        end else begin
          string t = tag_q.pop_front();
          check(t, cyc, exp_q.pop_front());
        end
        width = 0;
      end
      if (wdt_rst_o) width++;
      if (!wdt_rst_o && prev) check("R6 width", width, PULSE);
      prev = wdt_rst_o;
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int e, e2;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    rd(2'd3, "R1 status", 8'h00);
    check("R1 rst_o", wdt_rst_o, 0);

    wr(2'd0, 8'h37, e);
    rd(2'd0, "R2 readback", 8'h07);
    wr(2'd2, 8'h01, e);
    rd(2'd3, "R7 kick disarmed", 8'h00);

    // reload 3, arm, let it expire
    wr(2'd0, 8'h03, e);
    wr(2'd1, 8'h5A, e);
    expect_pulse(e + 3*P, "R5 expiry time");
    rd(2'd3, "R3 R8 armed status", 8'h83);
    repeat (P + P/2) @(negedge clk);
    rd(2'd3, "R5 one tick", 8'h82);
    repeat (3*P) @(negedge clk);
    rd(2'd3, "R6 self disarm", 8'h00);
    repeat (PULSE + 2) @(negedge clk);

    // trigger midway restarts countdown
    wr(2'd0, 8'h04, e);
    wr(2'd1, 8'h5A, e);
    repeat (2*P + P/2) @(negedge clk);
    wr(2'd2, 8'hFE, e2);
    rd(2'd3, "R7 bit0 clear no effect", 8'h82);
    wr(2'd2, 8'h01, e2);
    rd(2'd3, "R7 kick reload", 8'h84);
    expect_pulse(e2 + 4*P, "R7 kick expiry time");
    repeat (4*P + PULSE + 4) @(negedge clk);

    // disarm midway: count holds, no pulse
    wr(2'd0, 8'h05, e);
    wr(2'd1, 8'h5A, e);
    repeat (P + P/2) @(negedge clk);
    wr(2'd1, 8'h00, e);
    rd(2'd3, "R4 disarm", 8'h04);
    repeat (6*P) @(negedge clk);
    rd(2'd3, "R4 count holds", 8'h04);
    check("R4 no pulse", wdt_rst_o, 0);

    // reload 0 expires on first tick
    wr(2'd0, 8'h00, e);
    wr(2'd1, 8'h5A, e);
    expect_pulse(e + P, "R9 zero reload");
    repeat (P + PULSE + 4) @(negedge clk);
    rd(2'd3, "R9 disarmed", 8'h00);

    check("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule